// File: doc/BRIEF.md
# Shift and Rotate-Mask Unit

A purely combinational 64-bit shifter for the integer datapath of a scalar core. One operation code selects between a logical left shift, a logical or arithmetic right shift, a shift-left that first sign-extends the low word, and four rotate-left-then-mask operations. The four rotate operations differ in where the mask limits come from and in whether the bits outside the mask come from a second operand or are cleared. Every operation has a 32-bit mode. In that mode a shorter shift field is used and the result is confined to, or built from, the low word.

The rotate mask is set by a begin position and an end position. Both are numbered big-endian, so position 0 is the most significant bit. When the begin position lies after the end position, the mask wraps around the word. An opaque context word travels alongside the operands and comes back untouched. The output carries a valid flag, which is set only for the seven defined operation codes.

Top module: `sru_unit`

## Requirements
- R1: Operation codes are 1 shift-left, 2 shift-right, 3 sign-extend-shift-left, 4 rotate-clear with both limits immediate, 5 rotate-insert with both limits immediate, 6 rotate-clear with begin immediate and end from RB, and 7 rotate-clear with end immediate and begin from RB. For codes 1 to 7, valid_o is 1. For any other code, valid_o is 0 and result_o is all zeros.
- R2: ctx_o always equals ctx_i.
- R3: Shift-left in 64-bit mode gives RS shifted left by RB[6:0] and truncated to 64 bits, so amounts of 64 or more give zero. In 32-bit mode the low 32 bits are RS shifted left by RB[5:0] and truncated to 32 bits, and bits 63:32 are zero.
- R4: Shift-right with the signed flag clear is logical. In 64-bit mode it shifts RS right by RB[6:0]. In 32-bit mode it shifts RS[31:0] right by RB[5:0] and zeroes bits 63:32. Amounts at or beyond the width give zero.
- R5: Shift-right with the signed flag set in 32-bit mode shifts the signed value RS[31:0] right by RB[5:0], filling with RS[31]. Bits 63:32 of the result all equal RS[31].
- R6: Shift-right with the signed flag set in 64-bit mode shifts RS right by RB[6:0], filling with RS[63]. Amounts of 64 or more give 64 copies of RS[63].
- R7: Sign-extend-shift-left in 64-bit mode sign-extends RS[31:0] to 64 bits, then shifts it left by RB[6:0] and truncates to 64 bits. In 32-bit mode it gives the same result as R3.
- R8: Mask positions are 7-bit values. Result bit i has position 63-i. The begin mask covers every position at or after begin, and the end mask covers every position at or before end. The mask is the union of the two when begin > end (unsigned), and their intersection otherwise.
- R9: In 64-bit mode the rotated value is RS rotated left by RB[5:0]. In 32-bit mode RS[31:0] is rotated left by RB[4:0] within 32 bits and the word is copied into both halves. The immediate limits mb_i and me_i are used as they are in 64-bit mode, and as 32 plus their low 5 bits in 32-bit mode.
- R10: A limit taken from RB equals RB[5:0] in 32-bit mode. In 64-bit mode, a begin taken from RB is (RB[6:0] + 32) mod 128, and an end taken from RB is (63 - RB[6:0]) mod 128.
- R11: The rotate result is (rotated AND mask) OR (X AND NOT mask). X is RA for code 5 and zero for codes 4, 6 and 7, so RA has no effect on those codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1) |
| word32_i | input | 1 | 32-bit mode |
| signed_i | input | 1 | Arithmetic right shift when set |
| rs_i | input | 64 | Value to shift or rotate |
| rb_i | input | 64 | Shift or rotate amount, register mask limit |
| ra_i | input | 64 | Bits kept outside the mask for rotate-insert |
| mb_i | input | 6 | Immediate mask begin |
| me_i | input | 6 | Immediate mask end |
| ctx_i | input | 8 | Operation context in |
| result_o | output | 64 | Result |
| valid_o | output | 1 | Result valid |
| ctx_o | output | 8 | Operation context out |

## Verification
The bench uses the default parameters: a 64-bit datapath and an 8-bit context. With these, the 7-bit amount field reaches shift amounts from 64 to 127, which drive logical shifts to zero and arithmetic shifts to pure sign fill. In 32-bit mode the 6-bit field reaches amounts from 32 to 63, which do the same to the low word. Register-derived limits wrap modulo 128, so the bench can reach end limits beyond 63 and begin values of 64 or more, which give empty begin masks. Directed cases cover wrap and non-wrap masks in both modes, and random operands cover all sixteen operation codes.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [3:0] {
    SRU_NONE     = 4'd0,
    SRU_SHL      = 4'd1,
    SRU_SHR      = 4'd2,
    SRU_EXTSH    = 4'd3,
    SRU_ROT_CLR  = 4'd4,
    SRU_ROT_INS  = 4'd5,
    SRU_ROT_CLRL = 4'd6,
    SRU_ROT_CLRR = 4'd7
  } sru_op_e;

  function automatic logic sru_is_rot(input logic [3:0] op);
    return (op == SRU_ROT_CLR) || (op == SRU_ROT_INS) ||
           (op == SRU_ROT_CLRL) || (op == SRU_ROT_CLRR);
  endfunction

endpackage

// File: rtl/sru_shr.sv
module sru_shr #(
  parameter int W  = 64,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  d_i,
  input  logic [AW-1:0] amt_i,
  input  logic          fill_i,
  output logic [W-1:0]  d_o
);

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] prev;
    logic [W-1:0] q;
    if (k == 0) begin : g_first
      assign prev = d_i;
    end else begin : g_next
      assign prev = g_stage[k-1].q;
    end
    if (S >= W) begin : g_full
      assign q = amt_i[k] ? {W{fill_i}} : prev;
    end else begin : g_part
      assign q = amt_i[k] ? {{S{fill_i}}, prev[W-1:S]} : prev;
    end
  end

  assign d_o = g_stage[AW-1].q;

endmodule

// File: rtl/sru_rotl.sv
module sru_rotl #(
  parameter int W  = 64,
  parameter int FW = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [FW-1:0] amt_i,
  output logic [W-1:0]  d_o
);

  for (genvar k = 0; k < FW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] prev;
    logic [W-1:0] q;
    if (k == 0) begin : g_first
      assign prev = d_i;
    end else begin : g_next
      assign prev = g_stage[k-1].q;
    end
    assign q = amt_i[k] ? {prev[W-1-S:0], prev[W-1:W-S]} : prev;
  end

  assign d_o = g_stage[FW-1].q;

endmodule

// File: rtl/sru_rot_core.sv
module sru_rot_core #(
  parameter int W  = 64,
  parameter int FW = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [FW-1:0] amt_i,
  input  logic          half_i,
  output logic [W-1:0]  rot_o
);

  localparam int HW = W / 2;

  logic [W-1:0]  rot_full;
  logic [HW-1:0] rot_half;

  sru_rotl #(.W(W)) u_rot_full (
    .d_i  (d_i),
    .amt_i(amt_i),
    .d_o  (rot_full)
  );

  sru_rotl #(.W(HW)) u_rot_half (
    .d_i  (d_i[HW-1:0]),
    .amt_i(amt_i[FW-2:0]),
    .d_o  (rot_half)
  );

  assign rot_o = half_i ? {rot_half, rot_half} : rot_full;

  // rotation only moves bits, it never creates or drops them (R9)
  always_comb begin
    if (half_i) begin
      p_rot_pop_half_r9: assert ($countones(rot_o) == 2 * $countones(d_i[HW-1:0]));
    end else begin
      p_rot_pop_full_r9: assert ($countones(rot_o) == $countones(d_i));
    end
  end

endmodule

// File: rtl/sru_mask_gen.sv
module sru_mask_gen #(
  parameter int W  = 64,
  parameter int AW = $clog2(W) + 1
) (
  input  logic [AW-1:0] beg_i,
  input  logic [AW-1:0] end_i,
  output logic [W-1:0]  mask_o
);

  logic [W-1:0] from_beg;
  logic [W-1:0] to_end;
  logic         wrap;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [AW-1:0] POS = AW'(W - 1 - i);
    assign from_beg[i] = (POS >= beg_i);
    assign to_end[i]   = (POS <= end_i);
  end

  assign wrap   = (beg_i > end_i);
  assign mask_o = wrap ? (from_beg | to_end) : (from_beg & to_end);

  // a non-wrapping in-range window holds exactly end-begin+1 bits (R8)
  always_comb begin
    if (!wrap && (int'(end_i) < W)) begin
      p_mask_span_r8: assert ($countones(mask_o) == int'(end_i) - int'(beg_i) + 1);
    end
    if (wrap && (int'(beg_i) < W) && (int'(end_i) + 1 < int'(beg_i))) begin
      p_mask_gap_r8: assert ($countones(~mask_o) == int'(beg_i) - int'(end_i) - 1);
    end
  end

endmodule

// File: rtl/sru_unit.sv
module sru_unit #(
  parameter int W     = 64,
  parameter int CTX_W = 8
) (
  input  logic [3:0]       op_i,
  input  logic             word32_i,
  input  logic             signed_i,
  input  logic [W-1:0]     rs_i,
  input  logic [W-1:0]     rb_i,
  input  logic [W-1:0]     ra_i,
  input  logic [$clog2(W)-1:0] mb_i,
  input  logic [$clog2(W)-1:0] me_i,
  input  logic [CTX_W-1:0] ctx_i,
  output logic [W-1:0]     result_o,
  output logic             valid_o,
  output logic [CTX_W-1:0] ctx_o
);
  import sru_pkg::*;

  localparam int HW  = W / 2;
  localparam int FW  = $clog2(W);
  localparam int AW  = FW + 1;
  localparam int HAW = AW - 1;

  function automatic logic [W-1:0] rev_full(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  function automatic logic [HW-1:0] rev_half(input logic [HW-1:0] v);
    logic [HW-1:0] r;
    for (int i = 0; i < HW; i++) r[i] = v[HW-1-i];
    return r;
  endfunction

  // ---------------- shifts ----------------
  logic [W-1:0]  sext_lo;
  logic [W-1:0]  lsh_src;
  logic [W-1:0]  lsh_rev;
  logic [W-1:0]  rsh_full;
  logic [HW-1:0] lsh_half_rev;
  logic [HW-1:0] rsh_half;
  logic          fill_full;
  logic          fill_half;
  logic [W-1:0]  shl_res;
  logic [W-1:0]  shr_res;

  assign sext_lo   = {{HW{rs_i[HW-1]}}, rs_i[HW-1:0]};
  assign lsh_src   = (op_i == SRU_EXTSH) ? sext_lo : rs_i;
  assign fill_full = signed_i & rs_i[W-1];
  assign fill_half = signed_i & rs_i[HW-1];

  sru_shr #(.W(W)) u_lsh_full (
    .d_i   (rev_full(lsh_src)),
    .amt_i (rb_i[AW-1:0]),
    .fill_i(1'b0),
    .d_o   (lsh_rev)
  );

  sru_shr #(.W(W)) u_rsh_full (
    .d_i   (rs_i),
    .amt_i (rb_i[AW-1:0]),
    .fill_i(fill_full),
    .d_o   (rsh_full)
  );

  sru_shr #(.W(HW)) u_lsh_half (
    .d_i   (rev_half(rs_i[HW-1:0])),
    .amt_i (rb_i[HAW-1:0]),
    .fill_i(1'b0),
    .d_o   (lsh_half_rev)
  );

  sru_shr #(.W(HW)) u_rsh_half (
    .d_i   (rs_i[HW-1:0]),
    .amt_i (rb_i[HAW-1:0]),
    .fill_i(fill_half),
    .d_o   (rsh_half)
  );

  assign shl_res = word32_i ? {{HW{1'b0}}, rev_half(lsh_half_rev)} : rev_full(lsh_rev);
  assign shr_res = word32_i ? {{HW{fill_half}}, rsh_half} : rsh_full;

  // ---------------- rotate and mask ----------------
  logic [AW-1:0] imm_beg;
  logic [AW-1:0] imm_end;
  logic [AW-1:0] reg_beg;
  logic [AW-1:0] reg_end;
  logic [AW-1:0] mask_beg;
  logic [AW-1:0] mask_end;
  logic [W-1:0]  rotated;
  logic [W-1:0]  rot_mask;
  logic [W-1:0]  keep_src;
  logic [W-1:0]  rot_res;

  assign imm_beg = word32_i ? AW'(HW) + AW'(mb_i[FW-2:0]) : AW'(mb_i);
  assign imm_end = word32_i ? AW'(HW) + AW'(me_i[FW-2:0]) : AW'(me_i);
  assign reg_beg = word32_i ? AW'(rb_i[FW-1:0]) : rb_i[AW-1:0] + AW'(HW);
  assign reg_end = word32_i ? AW'(rb_i[FW-1:0]) : AW'(W - 1) - rb_i[AW-1:0];

  assign mask_beg = (op_i == SRU_ROT_CLRR) ? reg_beg : imm_beg;
  assign mask_end = (op_i == SRU_ROT_CLRL) ? reg_end : imm_end;

  sru_rot_core #(.W(W)) u_rot (
    .d_i   (rs_i),
    .amt_i (rb_i[FW-1:0]),
    .half_i(word32_i),
    .rot_o (rotated)
  );

  sru_mask_gen #(.W(W)) u_mask (
    .beg_i (mask_beg),
    .end_i (mask_end),
    .mask_o(rot_mask)
  );

  assign keep_src = (op_i == SRU_ROT_INS) ? ra_i : '0;
  assign rot_res  = (rotated & rot_mask) | (keep_src & ~rot_mask);

  // ---------------- output select ----------------
  always_comb begin
    valid_o  = 1'b1;
    result_o = '0;
    case (op_i)
      SRU_SHL, SRU_EXTSH: result_o = shl_res;
      SRU_SHR:            result_o = shr_res;
      SRU_ROT_CLR, SRU_ROT_INS, SRU_ROT_CLRL, SRU_ROT_CLRR:
                          result_o = rot_res;
      default:            valid_o  = 1'b0;
    endcase
  end

  assign ctx_o = ctx_i;

  // ---------------- checks ----------------
  always_comb begin
    if (!valid_o) begin
      p_idle_zero_r1: assert (result_o == '0);
    end
    if ((op_i == SRU_SHL) && word32_i) begin
      p_shl32_high_r3: assert (result_o[W-1:HW] == '0);
    end
    if ((op_i == SRU_SHR) && !signed_i && !word32_i && (rb_i[AW-1:0] >= AW'(W))) begin
      p_shr_flush_r4: assert (result_o == '0);
    end
    if ((op_i == SRU_SHR) && signed_i && word32_i) begin
      p_sra32_high_r5: assert (result_o[W-1:HW] == {HW{rs_i[HW-1]}});
    end
    if ((op_i == SRU_SHR) && signed_i && !word32_i) begin
      p_sra64_msb_r6: assert (result_o[W-1] == rs_i[W-1]);
    end
    if (sru_is_rot(op_i) && (op_i != SRU_ROT_INS)) begin
      p_clear_outside_r11: assert ((result_o & ~rot_mask) == '0);
    end
    if (op_i == SRU_ROT_INS) begin
      p_insert_keep_r11: assert ((result_o & ~rot_mask) == (ra_i & ~rot_mask));
    end
  end

endmodule

// File: tb/sru_unit_test.sv
module sru_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op;
  logic        w32;
  logic        sgn;
  logic [63:0] rs;
  logic [63:0] rb;
  logic [63:0] ra;
  logic [5:0]  mb;
  logic [5:0]  me;
  logic [7:0]  ctx;
  logic [63:0] result;
  logic        valid;
  logic [7:0]  ctx_out;

  int total = 0;
  int fails = 0;
  bit done  = 0;
  logic [7:0] ctx_seq = 8'h00;

  always #4 clk = ~clk;

  sru_unit uut (
    .op_i(op), .word32_i(w32), .signed_i(sgn), .rs_i(rs), .rb_i(rb),
    .ra_i(ra), .mb_i(mb), .me_i(me), .ctx_i(ctx),
    .result_o(result), .valid_o(valid), .ctx_o(ctx_out)
  );

  typedef struct {
    logic [63:0] res;
    logic        vld;
    logic [7:0]  ctx;
    string       tag;
  } exp_t;

  exp_t q[$];

  // reference model built bit by bit from the requirements
  function automatic logic [64:0] ref_model(
      input logic [3:0] o, input logic w, input logic s,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
      input logic [5:0] fb, input logic [5:0] fe);
    logic [63:0] r = '0;
    logic [63:0] x;
    logic [63:0] rot;
    logic [63:0] m;
    logic [31:0] wd;
    logic        v = 1'b1;
    logic        fill;
    int amt, n, bb, ee, ib, ie, rgb, rge, p;
    case (o)
      4'd1, 4'd3: begin
        x = (o == 4'd3 && !w) ? {{32{a[31]}}, a[31:0]} : a;
        if (w) begin
          amt = int'(b[5:0]);
          for (int i = 0; i < 32; i++) r[i] = (i - amt >= 0) ? x[i - amt] : 1'b0;
        end else begin
          amt = int'(b[6:0]);
          for (int i = 0; i < 64; i++) r[i] = (i - amt >= 0) ? x[i - amt] : 1'b0;
        end
      end
      4'd2: begin
        if (w) begin
          amt  = int'(b[5:0]);
          fill = s & a[31];
          for (int i = 0; i < 32; i++) r[i] = (i + amt < 32) ? a[i + amt] : fill;
          for (int i = 32; i < 64; i++) r[i] = fill;
        end else begin
          amt  = int'(b[6:0]);
          fill = s & a[63];
          for (int i = 0; i < 64; i++) r[i] = (i + amt < 64) ? a[i + amt] : fill;
        end
      end
      4'd4, 4'd5, 4'd6, 4'd7: begin
        if (w) begin
          n = int'(b[4:0]);
          for (int i = 0; i < 32; i++) wd[i] = a[(i - n + 32) % 32];
          rot = {wd, wd};
          ib  = 32 + int'(fb[4:0]);
          ie  = 32 + int'(fe[4:0]);
          rgb = int'(b[5:0]);
          rge = int'(b[5:0]);
        end else begin
          n = int'(b[5:0]);
          for (int i = 0; i < 64; i++) rot[i] = a[(i - n + 64) % 64];
          ib  = int'(fb);
          ie  = int'(fe);
          rgb = (int'(b[6:0]) + 32) % 128;
          rge = (63 - int'(b[6:0]) + 128) % 128;
        end
        bb = (o == 4'd7) ? rgb : ib;
        ee = (o == 4'd6) ? rge : ie;
        for (int i = 0; i < 64; i++) begin
          p = 63 - i;
          m[i] = (bb > ee) ? ((p >= bb) || (p <= ee)) : ((p >= bb) && (p <= ee));
        end
        r = (rot & m) | (((o == 4'd5) ? c : 64'd0) & ~m);
      end
      default: v = 1'b0;
    endcase
    return {v, r};
  endfunction

  task automatic drive(input logic [3:0] o, input logic w, input logic s,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                       input logic [5:0] fb, input logic [5:0] fe, input string tag);
    exp_t e;
    logic [64:0] mv;
    @(posedge clk);
    #1;
    ctx_seq = ctx_seq + 8'd37;
    op = o; w32 = w; sgn = s; rs = a; rb = b; ra = c; mb = fb; me = fe; ctx = ctx_seq;
    mv    = ref_model(o, w, s, a, b, c, fb, fe);
    e.vld = mv[64];
    e.res = mv[63:0];
    e.ctx = ctx_seq;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares at the falling edge, after the inputs have settled
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (result !== e.res || valid !== e.vld) begin
        fails++;
        $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                 e.tag, result, valid, e.res, e.vld);
      end
      total++;
      if (ctx_out !== e.ctx) begin
        fails++;
        $display("FAIL R2: ctx=%h expected %h", ctx_out, e.ctx);
      end
    end
  end

  function automatic string tag_of(input logic [3:0] o, input logic w, input logic s);
    case (o)
      4'd1: return "R3";
      4'd2: return s ? (w ? "R5" : "R6") : "R4";
      4'd3: return "R7";
      4'd4: return "R9";
      4'd5: return "R11";
      4'd6, 4'd7: return "R10";
      default: return "R1";
    endcase
  endfunction

  initial begin
    op = 4'd0; w32 = 0; sgn = 0; rs = '0; rb = '0; ra = '0; mb = '0; me = '0; ctx = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 idle state and undefined codes
    drive(4'd0, 0, 0, 64'd0, 64'd0, 64'd0, 6'd0, 6'd0, "R1");
    drive(4'd8, 0, 1, 64'hFFFF_0000_1234_5678, 64'd3, 64'hAAAA, 6'd1, 6'd9, "R1");
    drive(4'd15, 1, 0, 64'hDEAD_BEEF_CAFE_F00D, 64'd7, 64'h5555, 6'd2, 6'd3, "R1");

    // R3 left shift
    drive(4'd1, 0, 0, 64'h8000_0000_0000_00F1, 64'd4, 64'd0, 6'd0, 6'd0, "R3");
    drive(4'd1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 64'd0, 6'd0, 6'd0, "R3");
    drive(4'd1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 64'd0, 6'd0, 6'd0, "R3");
    drive(4'd1, 0, 0, 64'h0000_0000_0000_0011, 64'hFF00_0000_0000_0003, 64'd0, 6'd0, 6'd0, "R3");
    drive(4'd1, 1, 0, 64'hFFFF_FFFF_8765_4321, 64'd5, 64'd0, 6'd0, 6'd0, "R3");
    drive(4'd1, 1, 0, 64'hFFFF_FFFF_8765_4321, 64'd40, 64'd0, 6'd0, 6'd0, "R3");

    // R4 logical right shift
    drive(4'd2, 0, 0, 64'hF000_0000_0000_0000, 64'd100, 64'd0, 6'd0, 6'd0, "R4");
    drive(4'd2, 0, 0, 64'hF000_0000_0000_0000, 64'd60, 64'd0, 6'd0, 6'd0, "R4");
    drive(4'd2, 1, 0, 64'hFFFF_FFFF_8000_0000, 64'd31, 64'd0, 6'd0, 6'd0, "R4");

    // R5 32-bit arithmetic right shift
    drive(4'd2, 1, 1, 64'h0000_0000_8000_00F0, 64'd4, 64'd0, 6'd0, 6'd0, "R5");
    drive(4'd2, 1, 1, 64'h1234_5678_9000_0000, 64'd50, 64'd0, 6'd0, 6'd0, "R5");
    drive(4'd2, 1, 1, 64'hFFFF_FFFF_7000_0000, 64'd8, 64'd0, 6'd0, 6'd0, "R5");

    // R6 64-bit arithmetic right shift
    drive(4'd2, 0, 1, 64'h8000_0000_0000_0000, 64'd70, 64'd0, 6'd0, 6'd0, "R6");
    drive(4'd2, 0, 1, 64'h8123_0000_0000_0000, 64'd12, 64'd0, 6'd0, 6'd0, "R6");
    drive(4'd2, 0, 1, 64'h7FFF_0000_0000_0000, 64'd127, 64'd0, 6'd0, 6'd0, "R6");

    // R7 sign-extend then shift
    drive(4'd3, 0, 0, 64'h0000_0000_8000_0001, 64'd4, 64'd0, 6'd0, 6'd0, "R7");
    drive(4'd3, 0, 0, 64'hFFFF_FFFF_7000_0001, 64'd0, 64'd0, 6'd0, 6'd0, "R7");
    drive(4'd3, 1, 0, 64'h0000_0000_8000_0001, 64'd4, 64'd0, 6'd0, 6'd0, "R7");

    // R8/R9 rotate with immediate limits, wrap and non-wrap
    drive(4'd4, 0, 0, 64'h0123_4567_89AB_CDEF, 64'd12, 64'hFFFF, 6'd8, 6'd40, "R9");
    drive(4'd4, 0, 0, 64'h0123_4567_89AB_CDEF, 64'd12, 64'hFFFF, 6'd50, 6'd10, "R8");
    drive(4'd4, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 6'd63, 6'd0, "R8");
    drive(4'd4, 1, 0, 64'h5555_5555_8000_0001, 64'd33, 64'd0, 6'd0, 6'd31, "R9");
    drive(4'd4, 1, 0, 64'h0000_0000_F000_000F, 64'd4, 64'd0, 6'd28, 6'd3, "R8");

    // R11 insert versus clear
    drive(4'd5, 0, 0, 64'h0000_0000_0000_00FF, 64'd8, 64'hAAAA_AAAA_AAAA_AAAA, 6'd40, 6'd55, "R11");
    drive(4'd5, 1, 0, 64'h0000_0000_0000_00FF, 64'd8, 64'h5555_5555_5555_5555, 6'd16, 6'd23, "R11");
    drive(4'd4, 0, 0, 64'h0000_0000_0000_00FF, 64'd8, 64'hAAAA_AAAA_AAAA_AAAA, 6'd40, 6'd55, "R11");

    // R10 limits taken from RB
    drive(4'd6, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 64'd0, 6'd0, 6'd0, "R10");
    drive(4'd7, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 64'd0, 6'd0, 6'd63, "R10");
    drive(4'd6, 0, 0, 64'h0F0F_0F0F_0F0F_0F0F, 64'd100, 64'hFFFF, 6'd3, 6'd0, "R10");
    drive(4'd7, 0, 0, 64'h0F0F_0F0F_0F0F_0F0F, 64'd40, 64'hFFFF, 6'd0, 6'd9, "R10");
    drive(4'd6, 1, 0, 64'h0000_0000_8765_4321, 64'd40, 64'd0, 6'd2, 6'd0, "R10");
    drive(4'd7, 1, 0, 64'h0000_0000_8765_4321, 64'd36, 64'd0, 6'd0, 6'd20, "R10");

    // random sweep over every code
    for (int k = 0; k < 400; k++) begin
      logic [3:0]  ro;
      logic        rw;
      logic        rsg;
      logic [63:0] ra_v;
      logic [63:0] rs_v;
      logic [63:0] rb_v;
      ro   = 4'($urandom_range(0, 15));
      rw   = 1'($urandom_range(0, 1));
      rsg  = 1'($urandom_range(0, 1));
      rs_v = {$urandom, $urandom};
      ra_v = {$urandom, $urandom};
      rb_v = {$urandom, $urandom};
      drive(ro, rw, rsg, rs_v, rb_v, ra_v, 6'($urandom), 6'($urandom), tag_of(ro, rw, rsg));
    end

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule